// File: doc/BRIEF.md
# Programmable Sample Acquisition Timer

This block sets the length of the sampling window that comes before each conversion in a converter front end. The window opens on a start event and closes on an end event. Both events depend on the timing mode. When the mode input is low, the block is in free-running mode. A read-complete pulse arms the block, and the window opens when the converter-busy indication rises after that. An internal counter then closes the window after one of four cycle counts, chosen by a 2-bit length select.

When the mode input is high, the block is in externally timed mode and the length select has no effect. The window opens on either of two events: the strobe that latches a new input channel, or the falling edge of the busy indication, which marks the end of the previous conversion or calibration. The window closes when the external sync pin rises. That pin is first passed through two flip-flops before its rising edge is detected.

While the window is open, an active flag is high. When the window closes, the flag drops and a one-cycle done pulse tells the conversion engine to begin. A start event that arrives while a window is already open restarts that window from its beginning.

Top module: `acq_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `acq_active` and `acq_done` are both 0.
- R2: In free-running mode (`sync_mode`=0), the window lasts exactly 9, 15, 47 or 79 cycles for `len_sel` values 0, 1, 2 and 3. `acq_active` rises in the cycle after the clock edge that samples the start condition, and stays high for exactly that many cycles.
- R3: In free-running mode, the window opens only on a rise of `busy` that happens in the same cycle as a `rd_done` pulse or after one. A rise of `busy` with no preceding read-complete pulse does not open a window.
- R4: In externally timed mode, a one-cycle `chan_new` strobe opens a window at the next clock edge.
- R5: In externally timed mode, a falling edge of `busy` opens a window at the next clock edge, while a rising edge of `busy` does not.
- R6: In externally timed mode, the window closes on the third clock edge after `sync_in` rises, which is the cost of the two-flop synchronizer plus the edge register. The value of `len_sel` has no effect on this.
- R7: `acq_done` is high for exactly one cycle. It is high only in the cycle right after the last active cycle, and `acq_active` is 0 in that cycle.
- R8: A start event that arrives while a window is open restarts that window. In free-running mode, the full selected length is counted again from the restart.
- R9: In free-running mode, `sync_in` has no effect on the window length. A rise of `sync_in` while no window is open produces no `acq_done`.
- R10: The mode and length select are captured when the window starts. Changing `len_sel` during an open window does not change that window's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1 = window closed by the sync pin; 0 = window closed by the counter |
| len_sel | input | 2 | Length select for free-running mode |
| chan_new | input | 1 | One-cycle strobe: a new input channel was latched |
| busy | input | 1 | Converter busy indication (high while busy) |
| rd_done | input | 1 | One-cycle pulse: a result read has completed |
| sync_in | input | 1 | External window-end pin, asynchronous to `clk` |
| acq_active | output | 1 | High while the acquisition window is open |
| acq_done | output | 1 | One-cycle pulse when the window closes |

## Verification
The bench sweeps every length select in free-running mode and measures each window cycle by cycle. An off-by-one in the terminal count would show up as a window of 8 or 10 cycles, and a wrong length table would show up as the wrong count for one of the four codes. In externally timed mode, it tries both start events with every length select and several sync delays. A design that drops or adds a synchronizer stage would close the window one cycle early or late, and a design that still looks at `len_sel` in this mode would close the window on the counter. Two further checks catch a timer that starts without the read-complete arming and a timer that lets a mid-window change of `len_sel` take effect. Restart, stray sync edges and busy edges that should be ignored are each checked, so a design that lets any of them through would produce an extra or misplaced done pulse.

// File: rtl/acq_timer.sv
module acq_timer #(
  parameter int LEN0 = 9,
  parameter int LEN1 = 15,
  parameter int LEN2 = 47,
  parameter int LEN3 = 79
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_mode,
  input  logic [1:0] len_sel,
  input  logic       chan_new,
  input  logic       busy,
  input  logic       rd_done,
  input  logic       sync_in,
  output logic       acq_active,
  output logic       acq_done
);
  localparam int LMAX01 = (LEN0 > LEN1) ? LEN0 : LEN1;
  localparam int LMAX23 = (LEN2 > LEN3) ? LEN2 : LEN3;
  localparam int LMAX   = (LMAX01 > LMAX23) ? LMAX01 : LMAX23;
  localparam int CNT_W  = $clog2(LMAX + 1);

  logic             busy_q;
  logic             armed;
  logic [2:0]       sync_q;
  logic             mode_q;
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] win_len;

  always_comb begin
    case (sel_q)
      2'd0:    win_len = CNT_W'(LEN0);
      2'd1:    win_len = CNT_W'(LEN1);
      2'd2:    win_len = CNT_W'(LEN2);
      default: win_len = CNT_W'(LEN3);
    endcase
  end

  wire busy_rise   = busy & ~busy_q;
  wire busy_fall   = ~busy & busy_q;
  wire start_async = ~sync_mode & busy_rise & (armed | rd_done);
  wire start_sync  = sync_mode & (chan_new | busy_fall);
  wire start       = start_async | start_sync;
  wire sync_rise   = sync_q[1] & ~sync_q[2];
  wire end_async   = acq_active & ~mode_q & (cnt == win_len - CNT_W'(1));
  wire end_sync    = acq_active & mode_q & sync_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sync_q <= '0;
      armed  <= 1'b0;
    end else begin
      busy_q <= busy;
      sync_q <= {sync_q[1:0], sync_in};
      if (start_async)  armed <= 1'b0;
      else if (rd_done) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_active <= 1'b0;
      acq_done   <= 1'b0;
      mode_q     <= 1'b0;
      sel_q      <= '0;
      cnt        <= '0;
    end else if (start) begin
      acq_active <= 1'b1;
      acq_done   <= 1'b0;
      mode_q     <= sync_mode;
      sel_q      <= len_sel;
      cnt        <= '0;
    end else if (end_async || end_sync) begin
      acq_active <= 1'b0;
      acq_done   <= 1'b1;
      cnt        <= '0;
    end else begin
      acq_done <= 1'b0;
      if (acq_active && !mode_q) cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

module acq_timer_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_mode,
  input logic             chan_new,
  input logic             busy,
  input logic             mode_q,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] win_len,
  input logic             acq_active,
  input logic             acq_done
);
  a_r7_done_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |-> !acq_active);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |=> !acq_done);
  a_r7_done_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_done) |-> $past(acq_active));
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_active && !mode_q) |-> (cnt < win_len));
  a_r4_chan_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && chan_new) |=> acq_active);
  a_r5_busy_fall_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && $fell(busy)) |=> acq_active);
endmodule

bind acq_timer acq_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .chan_new(chan_new),
  .busy(busy), .mode_q(mode_q), .cnt(cnt), .win_len(win_len),
  .acq_active(acq_active), .acq_done(acq_done)
);

// File: tb/acq_timer_test.sv
module acq_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b0;
  logic [1:0] len_sel = 2'd0;
  logic chan_new = 1'b0;
  logic busy = 1'b0;
  logic rd_done = 1'b0;
  logic sync_in = 1'b0;
  logic acq_active, acq_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  acq_timer uut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .len_sel(len_sel),
    .chan_new(chan_new), .busy(busy), .rd_done(rd_done), .sync_in(sync_in),
    .acq_active(acq_active), .acq_done(acq_done)
  );

  always #2.5 clk = ~clk;

  function automatic int exp_len(input int s);
    return (s == 0) ? 9 : (s == 1) ? 15 : (s == 2) ? 47 : 79;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts active samples starting at the current negedge, ends on first inactive one
  task automatic measure(output int n);
    n = 0;
    while (acq_active && n < 300) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic done_tail(input string req);
    chk(acq_done == 1'b1 && acq_active == 1'b0, req, int'(acq_done), 1);
    @(negedge clk);
    chk(acq_done == 1'b0, {req, " single pulse"}, int'(acq_done), 0);
  endtask

  task automatic async_window(input int s, input string req);
    int n;
    sync_mode = 1'b0; len_sel = 2'(s); busy = 1'b0;
    @(negedge clk); rd_done = 1'b1;
    @(negedge clk); rd_done = 1'b0; busy = 1'b1;
    @(negedge clk);
    measure(n);
    chk(n == exp_len(s), req, n, exp_len(s));
    done_tail(req);
    busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic sync_window(input bit via_busy, input int s, input int k, input string req);
    int n;
    sync_mode = 1'b1; len_sel = 2'(s); sync_in = 1'b0;
    if (via_busy) begin
      busy = 1'b1; @(negedge clk);
      chk(acq_active == 1'b0, "R5 rise no start", int'(acq_active), 0);
      busy = 1'b0;
    end else begin
      chan_new = 1'b1;
    end
    @(negedge clk); chan_new = 1'b0;
    for (int i = 1; i < k; i++) @(negedge clk);
    chk(acq_active == 1'b1, req, int'(acq_active), 1);
    sync_in = 1'b1;
    @(negedge clk);
    measure(n);
    chk(n == 2, {req, " R6 sync latency"}, n, 2);
    done_tail("R6/R7 sync end");
    sync_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(acq_active == 1'b0 && acq_done == 1'b0, "R1 in reset", int'(acq_active), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(acq_active == 1'b0 && acq_done == 1'b0, "R1 after reset", int'(acq_done), 0);

    // R3: busy rises with no read-complete
    busy = 1'b1;
    repeat (3) @(negedge clk);
    chk(acq_active == 1'b0, "R3 unarmed rise", int'(acq_active), 0);
    busy = 1'b0;
    @(negedge clk);

    // R2 sweep
    for (int s = 0; s < 4; s++) async_window(s, "R2 length");

    // R9: sync idle rise in sync mode yields no done
    sync_mode = 1'b1; sync_in = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(acq_done == 1'b0 && acq_active == 1'b0, "R9 idle sync", int'(acq_done), 0);
    end
    sync_in = 1'b0; sync_mode = 1'b0;
    repeat (4) @(negedge clk);

    // R9: sync toggling during a free-running window
    len_sel = 2'd0;
    @(negedge clk); rd_done = 1'b1;
    @(negedge clk); rd_done = 1'b0; busy = 1'b1;
    @(negedge clk);
    sync_in = 1'b1;
    measure(n);
    chk(n == 9, "R9 sync ignored async", n, 9);
    done_tail("R9/R7 end");
    sync_in = 1'b0; busy = 1'b0;
    repeat (4) @(negedge clk);

    // R10: len_sel change mid-window
    len_sel = 2'd1;
    @(negedge clk); rd_done = 1'b1;
    @(negedge clk); rd_done = 1'b0; busy = 1'b1;
    @(negedge clk);
    repeat (3) @(negedge clk);
    len_sel = 2'd0;
    measure(n);
    chk(n + 3 == 15, "R10 captured select", n + 3, 15);
    done_tail("R10 end");
    busy = 1'b0;
    @(negedge clk);

    // R8: restart in free-running mode
    len_sel = 2'd0;
    @(negedge clk); rd_done = 1'b1;
    @(negedge clk); rd_done = 1'b0; busy = 1'b1;
    @(negedge clk);
    repeat (3) @(negedge clk);
    busy = 1'b0;
    @(negedge clk);
    chk(acq_active == 1'b1, "R8 busy fall async ignored", int'(acq_active), 1);
    rd_done = 1'b1; busy = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    measure(n);
    chk(n == 9, "R8 restart length", n, 9);
    done_tail("R8 end");
    busy = 1'b0;
    @(negedge clk);

    // R4/R5/R6 sweep in sync mode
    for (int s = 0; s < 4; s++) begin
      sync_window(1'b0, s, 1, "R4 chan start");
      sync_window(1'b1, s, 5, "R5 busy fall start");
      sync_window(1'b0, s, 100, "R6 select ignored");
    end

    // R8: restart in sync mode via chan_new
    sync_mode = 1'b1;
    chan_new = 1'b1; @(negedge clk); chan_new = 1'b0;
    repeat (3) @(negedge clk);
    chan_new = 1'b1; @(negedge clk); chan_new = 1'b0;
    chk(acq_active == 1'b1 && acq_done == 1'b0, "R8 sync restart", int'(acq_active), 1);
    sync_in = 1'b1;
    @(negedge clk);
    measure(n);
    chk(n == 2, "R8 sync restart end", n, 2);
    done_tail("R8 sync done");
    sync_in = 1'b0;
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule